// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between a producer on a write clock and a consumer on an unrelated read clock. The storage depth is a power-of-two parameter (2048 by default). Each pointer crosses into the other domain as a Gray code through a two-flop synchronizer. Occupancy flags are derived from these pointers: full, empty, a near-full flag and a near-empty flag with loadable thresholds, and a half-full flag.

Two read timing modes exist. The mode is sampled while the master reset is held. In request mode, a word reaches `rd_data` only after a read request. In fall-through mode, the oldest word moves to the output register without a request. That word no longer counts as stored, so every occupancy threshold sits one write later than in request mode.

A partial reset empties the FIFO and keeps the thresholds and the mode. A master reset also samples the mode and loads both thresholds with one of two defaults, picked by a select input. Software loads the thresholds through a small parallel port on the write clock, while the FIFO is idle.

Top module: `dcfifo_prog`

## Requirements
- R1: While either reset is low and after it is released, `empty`=1, `full`=0, `almost_full`=0, `almost_empty`=1, `half_full`=0, and `rd_data`=0.
- R2: Every accepted word is read out exactly once, in write order, in both modes.
- R3: A write request while `full`=1 is dropped: the write pointer does not move and later reads return only the words accepted earlier.
- R4: A read request while `empty`=1 is ignored. No pointer moves and the next written word is the next word read.
- R5: While `mrst_n` is low, both thresholds load 127 if `dflt_sel`=0, or 1023 if `dflt_sel`=1.
- R6: A write-clock cycle with `off_we`=1 loads `off_data` (any value 0 to DEPTH-1) into the near-full threshold F when `off_sel`=0, or into the near-empty threshold E when `off_sel`=1.
- R7: Let C be the number of words held in memory. In fall-through mode this excludes the word in the output register. `almost_full`=1 exactly when C >= DEPTH-F. With no reads this takes DEPTH-F writes in request mode and DEPTH-F+1 writes in fall-through mode.
- R8: `almost_empty`=1 exactly when C <= E. It clears after E+1 writes in request mode and E+2 writes in fall-through mode.
- R9: `half_full`=1 exactly when C > DEPTH/2. With no reads this takes DEPTH/2+1 writes in request mode and DEPTH/2+2 writes in fall-through mode.
- R10: `full`=1 exactly when C = DEPTH. This takes DEPTH writes in request mode and DEPTH+1 writes in fall-through mode.
- R11: Fall-through mode (`mode_sel`=1 at master reset): `empty`=0 means the oldest word is on `rd_data` without a request, and `rd_data` holds still until it is read. Request mode (`mode_sel`=0): `rd_data` changes only on an accepted read.
- R12: A partial reset keeps both thresholds and the mode. A master reset reloads the defaults and samples `mode_sel` anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| dflt_sel | input | 1 | Default threshold select sampled at master reset (0: 127, 1: 1023) |
| mode_sel | input | 1 | Mode sampled at master reset (0: request, 1: fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Write word |
| off_we | input | 1 | Threshold load strobe (write clock) |
| off_sel | input | 1 | 0: near-full threshold, 1: near-empty threshold |
| off_data | input | AW | Threshold value |
| full | output | 1 | Memory holds DEPTH words |
| almost_full | output | 1 | Near-full flag, two write-clock stages |
| half_full | output | 1 | More than DEPTH/2 words held |
| rd_en | input | 1 | Read request |
| rd_data | output | 9 | Output register |
| empty | output | 1 | No word available to read |
| almost_empty | output | 1 | Near-empty flag, two read-clock stages |

## Verification
A write pointer that moves while the FIFO is full, or a read pointer that moves while it is empty, shows up at `rd_data` as a duplicated, lost or out-of-order word. That error appears at the next read that reaches the damaged location, which can be up to a full depth of traffic later. A pointer that loses its Gray encoding during the crossing shows up as a flag that jumps by more than one threshold step. That error appears within the two synchronizer and two flag-stage cycles after the crossing. A threshold off by one, or a fall-through word counted as stored, moves the flag edges by exactly one write. The bench therefore checks every flag after every single write.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // near-full: words held plus threshold reach the depth
  function automatic logic reach_top(input logic [31:0] held, input logic [31:0] depth,
                                     input logic [31:0] thr);
    return (held + thr) >= depth;
  endfunction

  // near-empty: words held do not exceed the threshold
  function automatic logic below_floor(input logic [31:0] held, input logic [31:0] thr);
    return held <= thr;
  endfunction

  function automatic logic past_half(input logic [31:0] held, input logic [31:0] depth);
    return held > (depth >> 1);
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          dflt_sel,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic          off_we,
  input  logic          off_sel,
  input  logic [AW-1:0] off_data,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          push,
  output logic          full,
  output logic          almost_full,
  output logic          half_full,
  output logic [AW-1:0] thr_full,
  output logic [AW-1:0] thr_empty
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] held;
  logic [PW-1:0] wbin_nx;
  logic [AW-1:0] dflt;
  logic          af_raw;
  logic          hf_raw;
  logic [1:0]    af_pipe;

  assign rbin_s  = PW'(from_gray(32'(rgray_s)));
  assign held    = wbin - rbin_s;
  assign full    = (held == PW'(DEPTH));
  assign push    = wr_en && !full;
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(32'(wbin_nx)));
    end
  end

  assign af_raw = reach_top(32'(held), 32'(DEPTH), 32'(thr_full));
  assign hf_raw = past_half(32'(held), 32'(DEPTH));

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      af_pipe   <= 2'b00;
      half_full <= 1'b0;
    end else begin
      af_pipe   <= {af_pipe[0], af_raw};
      half_full <= hf_raw;
    end
  end
  assign almost_full = af_pipe[1];

  assign dflt = dflt_sel ? AW'(DEF_HI) : AW'(DEF_LO);

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      thr_full  <= dflt;
      thr_empty <= dflt;
    end else if (off_we) begin
      if (off_sel) thr_empty <= off_data;
      else         thr_full  <= off_data;
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_sel,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] thr_empty,
  input  logic [DW-1:0] ram_q,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          pop,
  output logic          fwft,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s;
  logic [PW-1:0] held;
  logic [PW-1:0] rbin_nx;
  logic          mem_has;
  logic          out_vld;
  logic          ae_raw;
  logic [1:0]    ae_pipe;

  // mode is captured on every read-clock edge while master reset is held
  always_ff @(posedge rclk) begin
    if (!mrst_n) fwft <= mode_sel;
  end

  assign wbin_s  = PW'(from_gray(32'(wgray_s)));
  assign held    = wbin_s - rbin;
  assign mem_has = (held != '0);
  assign rbin_nx = rbin + 1'b1;

  always_comb begin
    if (fwft) begin
      pop   = mem_has && (!out_vld || rd_en);
      empty = !out_vld;
    end else begin
      pop   = rd_en && mem_has;
      empty = !mem_has;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
      out_vld <= 1'b0;
    end else begin
      if (pop) begin
        rbin    <= rbin_nx;
        rgray   <= PW'(to_gray(32'(rbin_nx)));
        rd_data <= ram_q;
      end
      if (fwft) begin
        if (pop)                  out_vld <= 1'b1;
        else if (rd_en && out_vld) out_vld <= 1'b0;
      end else begin
        out_vld <= 1'b0;
      end
    end
  end

  assign ae_raw = below_floor(32'(held), 32'(thr_empty));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) ae_pipe <= 2'b11;
    else        ae_pipe <= {ae_pipe[0], ae_raw};
  end
  assign almost_empty = ae_pipe[1];
endmodule

// File: rtl/dcfifo_prog.sv
module dcfifo_prog #(
  parameter int DW     = 9,
  parameter int AW     = 11,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          dflt_sel,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          off_we,
  input  logic          off_sel,
  input  logic [AW-1:0] off_data,
  output logic          full,
  output logic          almost_full,
  output logic          half_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic          rst_n;
  logic [PW-1:0] wptr_bin, wptr_gray, wgray_s;
  logic [PW-1:0] rptr_bin, rptr_gray, rgray_s;
  logic          w_push, r_pop, fwft_mode;
  logic [AW-1:0] thr_full, thr_empty;
  logic [DW-1:0] ram_q;

  assign rst_n = mrst_n & prst_n;

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (w_push),
    .waddr (wptr_bin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rptr_bin[AW-1:0]),
    .rdata (ram_q)
  );

  dcf_sync #(.W(PW)) u_sync_r2w (
    .clk (wr_clk), .rst_n (rst_n), .d (rptr_gray), .q (rgray_s)
  );

  dcf_sync #(.W(PW)) u_sync_w2r (
    .clk (rd_clk), .rst_n (rst_n), .d (wptr_gray), .q (wgray_s)
  );

  dcf_wr_ctl #(.AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_wr (
    .wclk        (wr_clk),
    .rst_n       (rst_n),
    .mrst_n      (mrst_n),
    .dflt_sel    (dflt_sel),
    .wr_en       (wr_en),
    .rgray_s     (rgray_s),
    .off_we      (off_we),
    .off_sel     (off_sel),
    .off_data    (off_data),
    .wbin        (wptr_bin),
    .wgray       (wptr_gray),
    .push        (w_push),
    .full        (full),
    .almost_full (almost_full),
    .half_full   (half_full),
    .thr_full    (thr_full),
    .thr_empty   (thr_empty)
  );

  dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .rclk         (rd_clk),
    .rst_n        (rst_n),
    .mrst_n       (mrst_n),
    .mode_sel     (mode_sel),
    .rd_en        (rd_en),
    .wgray_s      (wgray_s),
    .thr_empty    (thr_empty),
    .ram_q        (ram_q),
    .rbin         (rptr_bin),
    .rgray        (rptr_gray),
    .rd_data      (rd_data),
    .pop          (r_pop),
    .fwft         (fwft_mode),
    .empty        (empty),
    .almost_empty (almost_empty)
  );
endmodule

// File: rtl/dcfifo_prog_chk.sv
module dcfifo_prog_chk #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          full,
  input logic [AW:0]   wptr_bin,
  input logic [AW:0]   wptr_gray,
  input logic          rd_en,
  input logic          empty,
  input logic [AW:0]   rptr_bin,
  input logic [AW:0]   rptr_gray,
  input logic          fwft_mode,
  input logic [DW-1:0] rd_data
);
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wr_en) |=> (wptr_bin == $past(wptr_bin)));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_mode && empty && rd_en) |=> (rptr_bin == $past(rptr_bin)));

  assert_wgray_step_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wptr_gray ^ $past(wptr_gray)));

  assert_rgray_step_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(rptr_gray ^ $past(rptr_gray)));

  assert_ft_hold_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (fwft_mode && !empty && !rd_en) |=> (!empty && $stable(rd_data)));

  assert_req_hold_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_mode && (empty || !rd_en)) |=> $stable(rd_data));
endmodule

bind dcfifo_prog dcfifo_prog_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .full      (full),
  .wptr_bin  (wptr_bin),
  .wptr_gray (wptr_gray),
  .rd_en     (rd_en),
  .empty     (empty),
  .rptr_bin  (rptr_bin),
  .rptr_gray (rptr_gray),
  .fwft_mode (fwft_mode),
  .rd_data   (rd_data)
);

// File: tb/dcfifo_prog_tb.sv
module dcfifo_prog_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW          = 9;
  localparam int AW          = 11;
  localparam int DEPTH       = 1 << AW;
  localparam int SETTLE      = 12;
  localparam int WDOG_CYC    = 190000;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, dflt_sel = 1'b0, mode_sel = 1'b0;
  logic wr_en = 1'b0, off_we = 1'b0, off_sel = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] off_data = '0;
  logic full, almost_full, half_full, empty, almost_empty;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] last_pop = '0;
  bit mon_ft = 0, req_pend = 0, done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

  dcfifo_prog #(.DW(DW), .AW(AW)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .dflt_sel(dflt_sel), .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data),
    .off_we(off_we), .off_sel(off_sel), .off_data(off_data), .full(full),
    .almost_full(almost_full), .half_full(half_full), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares read words against the queue of accepted writes
  always @(negedge rd_clk) begin
    if (mon_ft) begin
      if (rd_en && !empty) begin
        if (sb.size() == 0) check("R2", "read with nothing expected", 1, 0);
        else begin
          last_pop = sb.pop_front();
          check("R2", "read word", int'(rd_data), int'(last_pop));
        end
      end
    end else begin
      if (req_pend) begin
        if (sb.size() == 0) check("R2", "read with nothing expected", 1, 0);
        else begin
          last_pop = sb.pop_front();
          check("R2", "read word", int'(rd_data), int'(last_pop));
        end
      end
      req_pend = rd_en && !empty;
    end
  end

  task automatic settle();
    repeat (SETTLE) @(posedge wr_clk);
    #3;
  endtask

  task automatic wr(input logic [DW-1:0] d, input bit take);
    @(posedge wr_clk); #1;
    wr_en = 1'b1; wr_data = d;
    if (take) sb.push_back(d);
    @(posedge wr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    check(tag, "empty", int'(empty), 1);
    check(tag, "full", int'(full), 0);
    check(tag, "almost_full", int'(almost_full), 0);
    check(tag, "almost_empty", int'(almost_empty), 1);
    check(tag, "half_full", int'(half_full), 0);
  endtask

  task automatic master_reset(input bit dsel, input bit ft);
    @(posedge wr_clk); #1;
    mrst_n = 1'b0; dflt_sel = dsel; mode_sel = ft;
    rd_en = 1'b0; wr_en = 1'b0;
    repeat (4) @(posedge rd_clk);
    #3;
    check_idle("R1");
    check("R1", "rd_data in reset", int'(rd_data), 0);
    @(posedge wr_clk); #1;
    mrst_n = 1'b1;
    sb.delete(); req_pend = 0; mon_ft = ft; last_pop = '0;
    settle();
    check_idle("R1");
  endtask

  task automatic part_reset();
    @(posedge wr_clk); #1;
    prst_n = 1'b0; mode_sel = ~mode_sel; dflt_sel = ~dflt_sel;  // must be ignored (R12)
    repeat (4) @(posedge rd_clk);
    @(posedge wr_clk); #1;
    prst_n = 1'b1;
    sb.delete(); req_pend = 0; last_pop = '0;
    settle();
    check_idle("R1");
    check("R1", "rd_data after partial reset", int'(rd_data), 0);
  endtask

  task automatic load_thr(input int f, input int e);
    @(posedge wr_clk); #1;
    off_we = 1'b1; off_sel = 1'b0; off_data = AW'(f);
    @(posedge wr_clk); #1;
    off_sel = 1'b1; off_data = AW'(e);
    @(posedge wr_clk); #1;
    off_we = 1'b0;
  endtask

  // fills from empty with no reads, checking every flag after each write
  task automatic fill(input bit ft, input int f, input int e, input string thr_tag, input int salt);
    int cap = DEPTH + (ft ? 1 : 0);
    for (int w = 1; w <= cap; w++) begin
      logic [DW-1:0] d = DW'(w * 37 + salt);
      int c;
      wr(d, 1'b1);
      settle();
      c = ft ? w - 1 : w;
      check("R10", "full", int'(full), int'(c == DEPTH));
      check("R7", "almost_full", int'(almost_full), int'(c >= DEPTH - f));
      check("R8", "almost_empty", int'(almost_empty), int'(c <= e));
      check("R9", "half_full", int'(half_full), int'(c > DEPTH / 2));
      check("R2", "empty", int'(empty), 0);
      if (w == f || w == e + 1 || w == e + 2 || w == DEPTH - f || w == DEPTH - f + 1) begin
        check(thr_tag, "threshold in use, almost_empty", int'(almost_empty), int'(c <= e));
        check(thr_tag, "threshold in use, almost_full", int'(almost_full), int'(c >= DEPTH - f));
      end
      if (ft && w == 1) check("R11", "fall-through word without request", int'(rd_data), int'(d));
    end
    if (!ft) check("R11", "request mode rd_data unchanged without reads", int'(rd_data), 0);
    // overflow attempts
    for (int k = 0; k < 3; k++) wr(DW'(9'h0F0 + k), 1'b0);
    settle();
    check("R3", "full after dropped writes", int'(full), 1);
  endtask

  task automatic drain(input bit ft);
    @(posedge rd_clk); #1;
    rd_en = 1'b1;
    for (int i = 0; i < 4 * DEPTH && sb.size() > 0; i++) @(posedge rd_clk);
    repeat (6) @(posedge rd_clk);   // extra requests while empty (R4)
    #1;
    rd_en = 1'b0;
    settle();
    check("R2", "queue drained", sb.size(), 0);
    check_idle("R4");
    // pointer integrity after underflow attempts
    wr(9'h1A5, 1'b1);
    settle();
    check("R4", "empty after one write", int'(empty), 0);
    if (ft) check("R11", "fall-through shows word", int'(rd_data), 9'h1A5);
    else    check("R11", "request mode holds last read", int'(rd_data), int'(last_pop));
    @(posedge rd_clk); #1;
    rd_en = 1'b1;
    for (int i = 0; i < 50 && sb.size() > 0; i++) @(posedge rd_clk);
    #1;
    rd_en = 1'b0;
    settle();
    check("R4", "single word read back", sb.size(), 0);
    check("R4", "empty again", int'(empty), 1);
  endtask

  initial begin
    #(WDOG_CYC * CLK_PERIOD);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int md = 0; md < 2; md++) begin
      bit ft = (md == 1);
      int dflt = ft ? 1023 : 127;
      int f2 = ft ? 0 : 5;
      int e2 = ft ? DEPTH - 1 : 3;
      master_reset(ft, ft);           // R12: mode and defaults sampled here
      fill(ft, dflt, dflt, "R5", md * 11);
      drain(ft);
      load_thr(f2, e2);               // R6
      part_reset();                   // R12: thresholds and mode kept
      fill(ft, f2, e2, "R6", md * 11 + 5);
      check("R12", "mode kept across partial reset", int'(!ft && rd_data == '0) | int'(ft), 1);
      drain(ft);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule